// File: doc/BRIEF.md
# Single-Paddle Squash Game Engine

This block holds the game state of a one-player bat-and-ball game drawn on a 640x480 raster and produces the picture for it. A square ball travels inside a court closed by walls at the top, bottom and left. A vertical bat on the right-hand side guards the open edge, and the player moves it up and down. An external raster timing generator supplies the current pixel coordinates, a visible-area flag and a one-clock frame tick. The block answers with one bit each of red, green and blue for that pixel, together with a speaker enable that sounds a short tone whenever the ball bounces.

Game state (ball position, ball directions, bat position) changes only on the frame tick. The timing generator raises that tick at the start of vertical blanking, so a frame never shows a half-updated picture. All four buttons are active-low and pulled up. Pause freezes play. New Game restarts play, and the asynchronous reset restarts it in the same way. The colour outputs follow the pixel inputs combinationally, from the current state.

Top module: `squash_core`

## Requirements
- R1: After reset, and on any clock with `newgame_n` low (even while paused), the ball's top-left corner is at (316,236) moving right and down, and the bat's top row is 208.
- R2: Ball and bat positions change only on a clock with `frame_tick` high. On each such unpaused tick the ball moves exactly 1 pixel on each axis in its current direction.
- R3: A ball moving left with x = 8 flips to moving right and steps to x = 9. A ball moving up with y = 8 flips to moving down and steps to y = 9. A ball moving down with y + 8 = 472 flips to moving up and steps to y − 1.
- R4: A ball moving right with x + 8 = 600 whose rows overlap the bat (y + 8 > bat and y < bat + 64) flips to moving left and steps to x − 1.
- R5: A ball moving right that reaches x = 608 (past the bat column without a hit) is placed back at (316,236) on that tick, and keeps both direction bits.
- R6: On a tick, `up_n` low alone moves the bat up 4 rows, stopping at row 8. `down_n` low alone moves it down 4 rows, stopping so that its top is at row 408. Both pressed, or neither, leaves it still. The bat is 8 pixels wide (x 600..607) and 64 rows tall.
- R7: A tick with `pause_n` low changes neither ball nor bat.
- R8: Any bounce (R3 or R4) on a tick starts a tone. `spkr` is high for the 64 clocks following that tick, then alternates low and high every 64 clocks. The tone stops after 16 line starts (a clock with `px_x` = 0).
- R9: `spkr` is low whenever no tone is running, including after reset.
- R10: Pixel colour {r,g,b}: ball 110, bat 010, walls (x < 8, y < 8 or y ≥ 472) 111, else 000. Priority is ball, then bat, then wall. The output is 000 when `px_vis` is low, `px_x` ≥ 640 or `px_y` ≥ 480.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| px_x | input | 10 | Current pixel column |
| px_y | input | 10 | Current pixel row |
| px_vis | input | 1 | High inside the visible area |
| frame_tick | input | 1 | One-clock pulse at the start of vertical blanking |
| up_n | input | 1 | Bat up button, active low |
| down_n | input | 1 | Bat down button, active low |
| pause_n | input | 1 | Pause button, active low |
| newgame_n | input | 1 | New game button, active low |
| vga_r | output | 1 | Red pixel bit |
| vga_g | output | 1 | Green pixel bit |
| vga_b | output | 1 | Blue pixel bit |
| spkr | output | 1 | Speaker enable |

## Verification
The colour outputs are combinational, so the bench drives a coordinate on a falling edge and reads the colour 1 ns later, inside the same half-cycle. Ball and bat state is registered on the rising edge that sees `frame_tick`, and the bench reads positions through pixel probes only after that edge has passed. The tone register loads on the same tick edge, so the speaker checks count falling edges from that tick: high at 10, low at 70, high again at 130. Line-start pulses are each held for exactly one rising edge, so the 16-line expiry lands on a known edge.

// File: rtl/squash_pkg.sv
package squash_pkg;
  localparam int COORD_W = 10;
  typedef logic [COORD_W-1:0] coord_t;
  typedef logic [COORD_W:0]   wide_t;

  typedef struct packed {
    logic r;
    logic g;
    logic b;
  } rgb_t;

  function automatic wide_t wsum(coord_t a, coord_t b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // a + b lands exactly on c
  function automatic logic meets(coord_t a, coord_t b, coord_t c);
    return wsum(a, b) == {1'b0, c};
  endfunction

  // p in [lo, lo+len)
  function automatic logic in_span(coord_t p, coord_t lo, coord_t len);
    return ({1'b0, p} >= {1'b0, lo}) && ({1'b0, p} < wsum(lo, len));
  endfunction

  // [a, a+alen) and [b, b+blen) share at least one point
  function automatic logic overlaps(coord_t a, coord_t alen, coord_t b, coord_t blen);
    return (wsum(a, alen) > {1'b0, b}) && ({1'b0, a} < wsum(b, blen));
  endfunction

  function automatic coord_t step1(coord_t p, logic fwd);
    return fwd ? p + coord_t'(1) : p - coord_t'(1);
  endfunction
endpackage

// File: rtl/squash_ball.sv
module squash_ball
  import squash_pkg::*;
#(
  parameter coord_t H_VIS = 10'd640,
  parameter coord_t V_VIS = 10'd480,
  parameter coord_t WALL  = 10'd8,
  parameter coord_t BALL  = 10'd8,
  parameter coord_t PAD_X = 10'd600,
  parameter coord_t PAD_W = 10'd8,
  parameter coord_t PAD_H = 10'd64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   advance,
  input  coord_t pad_y,
  output coord_t ball_x,
  output coord_t ball_y,
  output logic   bounce,
  output logic   miss
);
  localparam coord_t X0     = coord_t'((H_VIS - BALL) / 2);
  localparam coord_t Y0     = coord_t'((V_VIS - BALL) / 2);
  localparam coord_t FLOOR  = V_VIS - WALL;
  localparam coord_t MISS_X = PAD_X + PAD_W;

  logic dir_x, dir_y;  // 1 = right / down
  logic hit_left, hit_pad, hit_top, hit_bot;
  logic nx_dir, ny_dir;

  always_comb begin
    hit_left = !dir_x && (ball_x == WALL);
    hit_pad  = dir_x && meets(ball_x, BALL, PAD_X) && overlaps(ball_y, BALL, pad_y, PAD_H);
    miss     = dir_x && (ball_x == MISS_X);
    hit_top  = !dir_y && (ball_y == WALL);
    hit_bot  = dir_y && meets(ball_y, BALL, FLOOR);
    bounce   = hit_left | hit_pad | hit_top | hit_bot;
    nx_dir   = (hit_left | hit_pad) ? ~dir_x : dir_x;
    ny_dir   = (hit_top | hit_bot) ? ~dir_y : dir_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ball_x <= X0;
      ball_y <= Y0;
      dir_x  <= 1'b1;
      dir_y  <= 1'b1;
    end else if (restart) begin
      ball_x <= X0;
      ball_y <= Y0;
      dir_x  <= 1'b1;
      dir_y  <= 1'b1;
    end else if (advance) begin
      dir_x <= nx_dir;
      dir_y <= ny_dir;
      if (miss) begin
        ball_x <= X0;
        ball_y <= Y0;
      end else begin
        ball_x <= step1(ball_x, nx_dir);
        ball_y <= step1(ball_y, ny_dir);
      end
    end
  end
endmodule

// File: rtl/squash_paddle.sv
module squash_paddle
  import squash_pkg::*;
#(
  parameter coord_t V_VIS = 10'd480,
  parameter coord_t WALL  = 10'd8,
  parameter coord_t PAD_H = 10'd64,
  parameter coord_t STEP  = 10'd4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   advance,
  input  logic   up_n,
  input  logic   down_n,
  output coord_t pad_y
);
  localparam coord_t Y0    = coord_t'((V_VIS - PAD_H) / 2);
  localparam coord_t Y_MAX = V_VIS - WALL - PAD_H;

  logic go_up, go_dn;
  coord_t next_y;

  always_comb begin
    go_up  = !up_n && down_n;
    go_dn  = up_n && !down_n;
    next_y = pad_y;
    if (go_up)
      next_y = (wsum(WALL, STEP) <= {1'b0, pad_y}) ? pad_y - STEP : WALL;
    else if (go_dn)
      next_y = (wsum(pad_y, STEP) <= {1'b0, Y_MAX}) ? pad_y + STEP : Y_MAX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pad_y <= Y0;
    else if (restart)  pad_y <= Y0;
    else if (advance)  pad_y <= next_y;
  end
endmodule

// File: rtl/squash_tone.sv
module squash_tone #(
  parameter int TONE_HALF  = 64,
  parameter int TONE_LINES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic start,
  input  logic line_start,
  output logic busy,
  output logic spkr
);
  localparam int DIV_W  = $clog2(TONE_HALF);
  localparam int LINE_W = $clog2(TONE_LINES + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(TONE_HALF - 1);
  localparam logic [LINE_W-1:0] LINES_INIT = LINE_W'(TONE_LINES);

  logic [DIV_W-1:0]  div_q;
  logic [LINE_W-1:0] left_q;
  logic              sq_q;

  assign busy = (left_q != '0);
  assign spkr = busy & sq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      left_q <= '0;
      sq_q   <= 1'b0;
    end else if (restart) begin
      div_q  <= '0;
      left_q <= '0;
      sq_q   <= 1'b0;
    end else if (start) begin
      div_q  <= '0;
      left_q <= LINES_INIT;
      sq_q   <= 1'b1;
    end else if (busy) begin
      div_q <= div_q + 1'b1;
      if (div_q == DIV_LAST) sq_q <= ~sq_q;
      if (line_start) left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/squash_render.sv
module squash_render
  import squash_pkg::*;
#(
  parameter coord_t H_VIS = 10'd640,
  parameter coord_t V_VIS = 10'd480,
  parameter coord_t WALL  = 10'd8,
  parameter coord_t BALL  = 10'd8,
  parameter coord_t PAD_X = 10'd600,
  parameter coord_t PAD_W = 10'd8,
  parameter coord_t PAD_H = 10'd64
) (
  input  coord_t px_x,
  input  coord_t px_y,
  input  logic   px_vis,
  input  coord_t ball_x,
  input  coord_t ball_y,
  input  coord_t pad_y,
  output rgb_t   pix
);
  localparam coord_t FLOOR = V_VIS - WALL;

  logic on_screen, on_ball, on_pad, on_wall;

  always_comb begin
    on_screen = px_vis && (px_x < H_VIS) && (px_y < V_VIS);
    on_ball   = in_span(px_x, ball_x, BALL) && in_span(px_y, ball_y, BALL);
    on_pad    = in_span(px_x, PAD_X, PAD_W) && in_span(px_y, pad_y, PAD_H);
    on_wall   = (px_x < WALL) || (px_y < WALL) || (px_y >= FLOOR);
    pix = '{r: 1'b0, g: 1'b0, b: 1'b0};
    if (on_screen) begin
      if (on_ball)      pix = '{r: 1'b1, g: 1'b1, b: 1'b0};
      else if (on_pad)  pix = '{r: 1'b0, g: 1'b1, b: 1'b0};
      else if (on_wall) pix = '{r: 1'b1, g: 1'b1, b: 1'b1};
    end
  end
endmodule

// File: rtl/squash_core.sv
module squash_core
  import squash_pkg::*;
#(
  parameter coord_t H_VIS    = 10'd640,
  parameter coord_t V_VIS    = 10'd480,
  parameter coord_t WALL     = 10'd8,
  parameter coord_t BALL     = 10'd8,
  parameter coord_t PAD_X    = 10'd600,
  parameter coord_t PAD_W    = 10'd8,
  parameter coord_t PAD_H    = 10'd64,
  parameter coord_t PAD_STEP = 10'd4,
  parameter int TONE_HALF    = 64,
  parameter int TONE_LINES   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] px_x,
  input  logic [9:0] px_y,
  input  logic       px_vis,
  input  logic       frame_tick,
  input  logic       up_n,
  input  logic       down_n,
  input  logic       pause_n,
  input  logic       newgame_n,
  output logic       vga_r,
  output logic       vga_g,
  output logic       vga_b,
  output logic       spkr
);
  // named internal events, visible to the bound checker
  logic   restart, advance, ball_bounce, ball_miss, tone_busy, line_start;
  coord_t ball_x, ball_y, pad_y;
  rgb_t   pix;

  assign restart    = !newgame_n;
  assign advance    = frame_tick && pause_n && !restart;
  assign line_start = (px_x == '0);

  squash_ball #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .WALL(WALL), .BALL(BALL),
    .PAD_X(PAD_X), .PAD_W(PAD_W), .PAD_H(PAD_H)
  ) ball_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
    .pad_y(pad_y), .ball_x(ball_x), .ball_y(ball_y),
    .bounce(ball_bounce), .miss(ball_miss)
  );

  squash_paddle #(
    .V_VIS(V_VIS), .WALL(WALL), .PAD_H(PAD_H), .STEP(PAD_STEP)
  ) pad_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
    .up_n(up_n), .down_n(down_n), .pad_y(pad_y)
  );

  squash_tone #(
    .TONE_HALF(TONE_HALF), .TONE_LINES(TONE_LINES)
  ) tone_i (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .start(advance && ball_bounce), .line_start(line_start),
    .busy(tone_busy), .spkr(spkr)
  );

  squash_render #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .WALL(WALL), .BALL(BALL),
    .PAD_X(PAD_X), .PAD_W(PAD_W), .PAD_H(PAD_H)
  ) draw_i (
    .px_x(px_x), .px_y(px_y), .px_vis(px_vis),
    .ball_x(ball_x), .ball_y(ball_y), .pad_y(pad_y), .pix(pix)
  );

  assign vga_r = pix.r;
  assign vga_g = pix.g;
  assign vga_b = pix.b;
endmodule

// File: rtl/squash_core_chk.sv
module squash_core_chk
  import squash_pkg::*;
#(
  parameter coord_t H_VIS = 10'd640,
  parameter coord_t V_VIS = 10'd480,
  parameter coord_t WALL  = 10'd8,
  parameter coord_t BALL  = 10'd8,
  parameter coord_t PAD_H = 10'd64
) (
  input logic   clk,
  input logic   rst_n,
  input logic   frame_tick,
  input logic   pause_n,
  input logic   newgame_n,
  input logic   px_vis,
  input coord_t px_x,
  input coord_t px_y,
  input logic   vga_r,
  input logic   vga_g,
  input logic   vga_b,
  input logic   spkr,
  input logic   tone_busy,
  input logic   ball_miss,
  input coord_t ball_x,
  input coord_t ball_y,
  input coord_t pad_y
);
  localparam coord_t X0 = coord_t'((H_VIS - BALL) / 2);
  localparam coord_t Y0 = coord_t'((V_VIS - BALL) / 2);
  localparam coord_t P0 = coord_t'((V_VIS - PAD_H) / 2);

  assert_newgame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !newgame_n |=> (ball_x == X0) && (ball_y == Y0) && (pad_y == P0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && newgame_n) |=> $stable(ball_x) && $stable(ball_y) && $stable(pad_y));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && pause_n && newgame_n && !ball_miss) |=>
      ((ball_x == $past(ball_x) + 1'b1) || (ball_x + 1'b1 == $past(ball_x))) &&
      ((ball_y == $past(ball_y) + 1'b1) || (ball_y + 1'b1 == $past(ball_y))));

  assert_recentre_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && pause_n && newgame_n && ball_miss) |=> (ball_x == X0) && (ball_y == Y0));

  assert_bat_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_y >= WALL) && ({1'b0, pad_y} + {1'b0, PAD_H} <= {1'b0, V_VIS - WALL}));

  assert_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !pause_n && newgame_n) |=> $stable(ball_x) && $stable(ball_y) && $stable(pad_y));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_busy |-> !spkr);

  assert_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!px_vis || (px_x >= H_VIS) || (px_y >= V_VIS)) |-> !(vga_r || vga_g || vga_b));
endmodule

bind squash_core squash_core_chk #(
  .H_VIS(H_VIS), .V_VIS(V_VIS), .WALL(WALL), .BALL(BALL), .PAD_H(PAD_H)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .pause_n(pause_n),
  .newgame_n(newgame_n), .px_vis(px_vis), .px_x(px_x), .px_y(px_y),
  .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b), .spkr(spkr),
  .tone_busy(tone_busy), .ball_miss(ball_miss),
  .ball_x(ball_x), .ball_y(ball_y), .pad_y(pad_y)
);

// File: tb/squash_core_tb_top.sv
module squash_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] px_x = 10'd5, px_y = 10'd5;
  logic px_vis = 1'b0, frame_tick = 1'b0;
  logic up_n = 1'b1, down_n = 1'b1, pause_n = 1'b1, newgame_n = 1'b1;
  logic vga_r, vga_g, vga_b, spkr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  squash_core dut_i (
    .clk(clk), .rst_n(rst_n), .px_x(px_x), .px_y(px_y), .px_vis(px_vis),
    .frame_tick(frame_tick), .up_n(up_n), .down_n(down_n),
    .pause_n(pause_n), .newgame_n(newgame_n),
    .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b), .spkr(spkr)
  );

  // {vis, x, y, expected rgb} for the reset picture: ball 316..323 x 236..243, bat rows 208..271
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 10'd320, 10'd240, 3'd6},
    {1'b1, 10'd316, 10'd236, 3'd6},
    {1'b1, 10'd323, 10'd243, 3'd6},
    {1'b1, 10'd315, 10'd240, 3'd0},
    {1'b1, 10'd603, 10'd210, 3'd2},
    {1'b1, 10'd607, 10'd271, 3'd2},
    {1'b1, 10'd607, 10'd272, 3'd0},
    {1'b1, 10'd3,   10'd100, 3'd7},
    {1'b1, 10'd100, 10'd3,   3'd7},
    {1'b1, 10'd100, 10'd476, 3'd7},
    {1'b1, 10'd630, 10'd100, 3'd0},
    {1'b0, 10'd320, 10'd240, 3'd0},
    {1'b1, 10'd640, 10'd100, 3'd0},
    {1'b1, 10'd100, 10'd480, 3'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pix(input bit vis, input int x, input int y, output int rgb);
    @(negedge clk);
    px_vis = vis; px_x = 10'(x); px_y = 10'(y);
    #1 rgb = {29'd0, vga_r, vga_g, vga_b};
    px_vis = 1'b0; px_x = 10'd5; px_y = 10'd5;
  endtask

  task automatic tick();
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic ball_at(input string req, input int x, input int y);
    int c;
    pix(1, x, y, c);         chk({req, " ball corner"}, c, 6);
    pix(1, x + 7, y + 7, c); chk({req, " ball far corner"}, c, 6);
    pix(1, x - 1, y, c);     chk({req, " left of ball"}, int'(c == 6), 0);
    pix(1, x, y - 1, c);     chk({req, " above ball"}, int'(c == 6), 0);
  endtask

  task automatic bat_top(input string req, input int y);
    int c;
    pix(1, 600, y, c);     chk({req, " bat top row"}, c, 2);
    pix(1, 600, y - 1, c); chk({req, " above bat"}, int'(c == 2), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: colour table against the reset picture
    for (int i = 0; i < NV; i++) begin
      pix(VEC[i][23], int'(VEC[i][22:13]), int'(VEC[i][12:3]), c);
      chk($sformatf("R10 vector %0d", i), c, int'(VEC[i][2:0]));
    end

    // R1 reset state, R9 silent
    ball_at("R1 reset", 316, 236);
    bat_top("R1 reset", 208);
    chk("R9 silent after reset", int'(spkr), 0);

    // R7 pause freezes play
    pause_n = 1'b0; ticks(5); pause_n = 1'b1;
    ball_at("R7 paused", 316, 236);
    bat_top("R7 paused", 208);

    // R6 both buttons: no bat motion; R2 one-pixel step
    up_n = 1'b0; down_n = 1'b0; tick(); up_n = 1'b1; down_n = 1'b1;
    ball_at("R2 step", 317, 237);
    bat_top("R6 both pressed", 208);
    up_n = 1'b0; tick(); up_n = 1'b1;
    bat_top("R6 up", 204);
    ball_at("R2 step", 318, 238);
    repeat (20) @(negedge clk);
    ball_at("R2 no tick", 318, 238);

    down_n = 1'b0; ticks(41); down_n = 1'b1;   // tick 43
    bat_top("R6 down", 368);
    ball_at("R2 run", 359, 279);

    ticks(185);                                // tick 228
    ball_at("R3 pre floor", 544, 464);
    chk("R9 silent before bounce", int'(spkr), 0);

    tick();                                    // tick 229: floor bounce
    repeat (10) @(negedge clk); chk("R8 tone high phase", int'(spkr), 1);
    repeat (60) @(negedge clk); chk("R8 tone low phase", int'(spkr), 0);
    repeat (60) @(negedge clk); chk("R8 tone high again", int'(spkr), 1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk) px_x = 10'd0;
      @(negedge clk) px_x = 10'd5;
      repeat (3) @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      repeat (40) @(negedge clk);
      chk("R8 tone over after 16 lines", int'(spkr), 0);
    end
    ball_at("R3 floor bounce", 545, 463);

    ticks(47);                                 // tick 276
    ball_at("R4 at bat", 592, 416);
    tick();                                    // tick 277: bat bounce
    ball_at("R4 bat bounce", 591, 415);

    ticks(408);                                // tick 685: ceiling bounce
    ball_at("R3 ceiling bounce", 183, 9);
    ticks(176);                                // tick 861: left wall bounce
    ball_at("R3 left wall bounce", 9, 185);

    // R1 new game overrides pause
    pause_n = 1'b0; newgame_n = 1'b0;
    repeat (2) @(negedge clk);
    newgame_n = 1'b1; pause_n = 1'b1;
    ball_at("R1 new game", 316, 236);
    bat_top("R1 new game", 208);
    chk("R9 silent after new game", int'(spkr), 0);

    // R5 miss with bat left at 208
    ticks(292);
    ball_at("R5 past bat", 608, 400);
    tick();
    ball_at("R5 recentred", 316, 236);
    tick();
    ball_at("R5 directions kept", 317, 235);

    // R6 clamps
    newgame_n = 1'b0; @(negedge clk); newgame_n = 1'b1;
    up_n = 1'b0; ticks(60); up_n = 1'b1;
    bat_top("R6 top clamp", 8);
    pix(1, 600, 7, c); chk("R6 wall above bat", c, 7);
    down_n = 1'b0; ticks(120); down_n = 1'b1;
    pix(1, 600, 471, c); chk("R6 bottom clamp bat row", c, 2);
    pix(1, 600, 472, c); chk("R6 wall below bat", c, 7);
    bat_top("R6 bottom clamp", 408);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule